// File: doc/BRIEF.md
# Interleaved Slice Result Collector with Overrange Saturation

This block gathers conversion results from a ring of time-interleaved converter slices and turns them into one output word stream, one word per clock. An internal interleave phase counter names the slice that samples in each cycle. A slice's result is taken from its bus thirteen cycles after its sample cycle, during its transfer step, and is registered on the next rising edge. The word therefore reaches the output fourteen clocks after that slice sampled.

Each slice bus is 13 bits wide. Bit 12 flags an overrange and bits 11:0 hold a straight-binary code: 0x000 at the bottom of the range and 0xFFF at full scale. When the overrange bit of the selected slice is set, the registered data word is forced to all ones and a separate overrange output goes high. A valid output stays low after reset until the first slice's word reaches the output. A source index output names the slice that produced the current word.

Top module: `ilv_result_mux`

## Requirements
- R1: While rst_ni is low, data_o, ovr_o, valid_o, samp_idx_o and src_idx_o are all 0.
- R2: samp_idx_o is 0 in the first cycle after reset release and advances by one on every rising edge, wrapping from 17 to 0.
- R3: In cycle n (n ≥ 14, counting the first cycle after reset release as cycle 0), data_o and ovr_o carry the result of slice (n−14) mod 18, as that slice held it on its bus during cycle n−1. Slice k occupies bits [13k+12:13k] of slice_res_i.
- R4: Whenever valid_o is high, src_idx_o equals (samp_idx_o − 14) mod 18.
- R5: valid_o is low in cycles 0 to 13 after reset release, goes high in cycle 14 and stays high until the next reset.
- R6: When bit 12 of the selected slice result is 0, data_o equals bits 11:0 unchanged, including the end codes 0x000 and 0xFFF, and ovr_o is 0.
- R7: When bit 12 of the selected slice result is 1, ovr_o is 1 and data_o is 0xFFF, whatever bits 11:0 hold.
- R8: The buses of slices not in their transfer step have no effect on data_o or ovr_o, even when they carry overrange or extreme codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all outputs update on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slice_res_i | input | 234 | 18 slice results, 13 bits each, slice k in bits [13k+12:13k] |
| data_o | output | 12 | Registered straight-binary data word |
| ovr_o | output | 1 | Registered overrange flag |
| valid_o | output | 1 | High once the first converted word has reached the output |
| samp_idx_o | output | 5 | Slice sampling in the current cycle (interleave phase) |
| src_idx_o | output | 5 | Slice whose result is on data_o and ovr_o |

## Verification
The hardest case to reach from the ports is a wrong pairing between phase and slice. If the block pulls the word from a neighbouring slice, or one cycle early or late, it still outputs a plausible code. The stimulus therefore gives every slice a distinct value in every cycle, built from both the slice number and the cycle count, so a shifted select or a misplaced register stage produces a different code. For the saturation and isolation cases, the slices outside their transfer step are filled with overrange and full-scale codes while the selected slice holds a small in-range code. Any leak from a non-selected slice then shows up at once on ovr_o or data_o.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;
  localparam int unsigned DATA_W   = 12;
  localparam int unsigned RES_W    = DATA_W + 1;
  localparam int unsigned N_SLICES = 18;
  localparam int unsigned LAT_CYC  = 14;

  typedef struct packed {
    logic              ovr;
    logic [DATA_W-1:0] data;
  } res_t;
endpackage

// File: rtl/ilv_phase_gen.sv
`timescale 1ns/1ps
module ilv_phase_gen #(
  parameter int unsigned N     = 18,
  parameter int unsigned LAT   = 14,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] samp_idx_o,
  output logic [IDX_W-1:0] sel_idx_o,
  output logic             valid_d_o
);
  // slice in transfer step sampled LAT-1 cycles ago
  localparam int unsigned OFS   = (N - ((LAT - 1) % N)) % N;
  localparam int unsigned CNT_W = $clog2(LAT);

  logic [IDX_W-1:0] phase_q;
  logic [CNT_W-1:0] warm_q;
  logic             warm_done_q;
  logic [IDX_W:0]   sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (phase_q == IDX_W'(N - 1)) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q      <= '0;
      warm_done_q <= 1'b0;
    end else if (!warm_done_q) begin
      if (warm_q == CNT_W'(LAT - 1)) warm_done_q <= 1'b1;
      else                           warm_q      <= warm_q + 1'b1;
    end
  end

  always_comb begin
    sum = {1'b0, phase_q} + (IDX_W+1)'(OFS);
    if (sum >= (IDX_W+1)'(N)) sum = sum - (IDX_W+1)'(N);
  end

  assign samp_idx_o = phase_q;
  assign sel_idx_o  = sum[IDX_W-1:0];
  // high during the cycle whose edge first registers a converted word
  assign valid_d_o  = warm_done_q || (warm_q == CNT_W'(LAT - 1));
endmodule

// File: rtl/ilv_slice_mux.sv
`timescale 1ns/1ps
module ilv_slice_mux
  import ilv_pkg::*;
#(
  parameter int unsigned N     = 18,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N*RES_W-1:0] bus_i,
  input  logic [IDX_W-1:0]   sel_i,
  output res_t               res_o
);
  logic [N-1:0]       hit;
  logic [RES_W-1:0]   masked [N];

  for (genvar g = 0; g < N; g++) begin : g_slice
    assign hit[g]    = (sel_i == IDX_W'(g));
    assign masked[g] = hit[g] ? bus_i[g*RES_W +: RES_W] : '0;
  end

  always_comb begin
    logic [RES_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc | masked[i];
    res_o = res_t'(acc);
  end
endmodule

// File: rtl/ilv_sat_clamp.sv
`timescale 1ns/1ps
module ilv_sat_clamp
  import ilv_pkg::*;
(
  input  res_t res_i,
  output res_t res_o
);
  always_comb begin
    res_o.ovr  = res_i.ovr;
    res_o.data = res_i.ovr ? {DATA_W{1'b1}} : res_i.data;
  end
endmodule

// File: rtl/ilv_out_reg.sv
`timescale 1ns/1ps
module ilv_out_reg
  import ilv_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  res_t             res_i,
  input  logic [IDX_W-1:0] src_i,
  input  logic             valid_i,
  output res_t             res_o,
  output logic [IDX_W-1:0] src_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      src_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      res_o   <= res_i;
      src_o   <= src_i;
      valid_o <= valid_i;
    end
  end
endmodule

// File: rtl/ilv_result_mux.sv
`timescale 1ns/1ps
module ilv_result_mux
  import ilv_pkg::*;
#(
  parameter int unsigned N     = N_SLICES,
  parameter int unsigned LAT   = LAT_CYC,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N*RES_W-1:0] slice_res_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               ovr_o,
  output logic               valid_o,
  output logic [IDX_W-1:0]   samp_idx_o,
  output logic [IDX_W-1:0]   src_idx_o
);
  logic [IDX_W-1:0] sel_idx;
  logic             valid_d;
  res_t             mux_res, sat_res, out_res;

  ilv_phase_gen #(.N(N), .LAT(LAT), .IDX_W(IDX_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .samp_idx_o (samp_idx_o),
    .sel_idx_o  (sel_idx),
    .valid_d_o  (valid_d)
  );

  ilv_slice_mux #(.N(N), .IDX_W(IDX_W)) u_mux (
    .bus_i (slice_res_i),
    .sel_i (sel_idx),
    .res_o (mux_res)
  );

  ilv_sat_clamp u_clamp (
    .res_i (mux_res),
    .res_o (sat_res)
  );

  ilv_out_reg #(.IDX_W(IDX_W)) u_oreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .res_i   (sat_res),
    .src_i   (sel_idx),
    .valid_i (valid_d),
    .res_o   (out_res),
    .src_o   (src_idx_o),
    .valid_o (valid_o)
  );

  assign data_o = out_res.data;
  assign ovr_o  = out_res.ovr;
endmodule

// File: rtl/ilv_result_mux_chk.sv
`timescale 1ns/1ps
module ilv_result_mux_chk
  import ilv_pkg::*;
#(
  parameter int unsigned N     = N_SLICES,
  parameter int unsigned LAT   = LAT_CYC,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N*RES_W-1:0] slice_res_i,
  input logic [DATA_W-1:0]  data_o,
  input logic               ovr_o,
  input logic               valid_o,
  input logic [IDX_W-1:0]   samp_idx_o,
  input logic [IDX_W-1:0]   src_idx_o
);
  logic [N*RES_W-1:0] bus_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_q <= '0;
    else         bus_q <= slice_res_i;
  end

  function automatic logic [RES_W-1:0] expect_f(logic [N*RES_W-1:0] b, logic [IDX_W-1:0] s);
    logic [RES_W-1:0] w;
    w = b[s*RES_W +: RES_W];
    return w[RES_W-1] ? {RES_W{1'b1}} : w;
  endfunction

  function automatic logic [IDX_W-1:0] back_f(logic [IDX_W-1:0] p);
    int unsigned v;
    v = (int'(p) + N - (LAT % N)) % N;
    return IDX_W'(v);
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (!valid_o && !ovr_o && data_o == '0 && samp_idx_o == '0 && src_idx_o == '0);
    end
  end

  assert_phase_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> samp_idx_o == (($past(samp_idx_o) == IDX_W'(N - 1)) ? '0 : $past(samp_idx_o) + 1'b1));

  assert_word_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> {ovr_o, data_o} == expect_f(bus_q, src_idx_o));

  assert_src_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> src_idx_o == back_f(samp_idx_o));

  assert_valid_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  assert_valid_onset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> samp_idx_o == IDX_W'(LAT % N));

  assert_ovr_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> data_o == {DATA_W{1'b1}});
endmodule

bind ilv_result_mux ilv_result_mux_chk #(.N(N), .LAT(LAT), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slice_res_i (slice_res_i),
  .data_o      (data_o),
  .ovr_o       (ovr_o),
  .valid_o     (valid_o),
  .samp_idx_o  (samp_idx_o),
  .src_idx_o   (src_idx_o)
);

// File: tb/ilv_result_mux_tb_top.sv
`timescale 1ns/1ps
module ilv_result_mux_tb_top;
  localparam int NS  = 18;
  localparam int RW  = 13;
  localparam int LAT = 14;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NS*RW-1:0] slice_res_i = '0;
  logic [11:0]    data_o;
  logic           ovr_o, valid_o;
  logic [4:0]     samp_idx_o, src_idx_o;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit done   = 1'b0;
  logic [NS*RW-1:0] prev_bus = '0;
  logic [12:0] codes [NS];

  always #4 clk_i = ~clk_i;

  ilv_result_mux dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .slice_res_i(slice_res_i),
    .data_o(data_o), .ovr_o(ovr_o), .valid_o(valid_o),
    .samp_idx_o(samp_idx_o), .src_idx_o(src_idx_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, n);
    end
  endtask

  function automatic logic [NS*RW-1:0] pack_codes();
    logic [NS*RW-1:0] b;
    for (int k = 0; k < NS; k++) b[k*RW +: RW] = codes[k];
    return b;
  endfunction

  // check outputs of cycle n against bus driven during cycle n-1
  task automatic check_cycle();
    int s;
    logic [12:0] w;
    chk(samp_idx_o == 5'(n % NS), "R2 samp_idx", samp_idx_o, n % NS);
    if (n < LAT) begin
      chk(valid_o == 1'b0, "R5 valid low", valid_o, 0);
    end else begin
      s = (n - LAT) % NS;
      w = prev_bus[s*RW +: RW];
      chk(valid_o == 1'b1, "R5 valid high", valid_o, 1);
      chk(src_idx_o == 5'(s), "R4 src_idx", src_idx_o, s);
      if (w[12]) begin
        chk(ovr_o == 1'b1, "R7 ovr flag", ovr_o, 1);
        chk(data_o == 12'hFFF, "R7 clamp", data_o, 12'hFFF);
      end else begin
        chk(ovr_o == 1'b0, "R6 ovr clear", ovr_o, 0);
        chk(data_o == w[11:0], "R3 R6 R8 data", data_o, w[11:0]);
      end
    end
  endtask

  task automatic step();
    slice_res_i = pack_codes();
    @(posedge clk_i);
    n++;
    prev_bus = slice_res_i;
    @(negedge clk_i);
    check_cycle();
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    for (int k = 0; k < NS; k++) codes[k] = 13'h1ABC ^ 13'(k);
    slice_res_i = pack_codes();
    repeat (3) @(negedge clk_i);
    chk(data_o == 12'h0, "R1 data", data_o, 0);
    chk(ovr_o == 1'b0, "R1 ovr", ovr_o, 0);
    chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
    chk(samp_idx_o == 5'd0, "R1 samp_idx", samp_idx_o, 0);
    chk(src_idx_o == 5'd0, "R1 src_idx", src_idx_o, 0);
    rst_ni = 1'b1;
    n = 0;
    check_cycle();
  endtask

  // R5 warm-up and R2 wrap, with in-range codes
  task automatic t_warmup();
    for (int c = 0; c < 2 * NS; c++) begin
      for (int k = 0; k < NS; k++) codes[k] = {1'b0, 12'(k * 229 + n * 7)};
      step();
    end
  endtask

  // R3 order: every slice value depends on slice and cycle
  task automatic t_order();
    for (int c = 0; c < 6 * NS; c++) begin
      for (int k = 0; k < NS; k++) codes[k] = {1'b0, 12'((k << 7) ^ (n * 37 + 5))};
      step();
    end
  endtask

  // R7 clamp on selected slice, R8 isolation: neighbours carry overrange
  task automatic t_clamp_isolation();
    for (int c = 0; c < 4 * NS; c++) begin
      int sel;
      sel = (n + 1 - LAT + 4 * NS) % NS;  // slice selected during this cycle
      for (int k = 0; k < NS; k++) codes[k] = (c % 2 == 0) ? 13'h1FFF : 13'h1000;
      if (c % 3 == 0) codes[sel] = {1'b1, 12'(n * 91)};
      else            codes[sel] = {1'b0, 12'(n * 13 + 1)};
      step();
    end
  endtask

  // R6 end codes with R8 neighbours at the opposite extreme
  task automatic t_endcodes();
    for (int c = 0; c < 2 * NS; c++) begin
      int sel;
      sel = (n + 1 - LAT + 4 * NS) % NS;
      for (int k = 0; k < NS; k++) codes[k] = (c % 2 == 0) ? 13'h1FFF : 13'h0FFF;
      codes[sel] = (c % 2 == 0) ? 13'h0000 : 13'h0FFF;
      if (c % 4 == 1) for (int k = 0; k < NS; k++) if (k != sel) codes[k] = 13'h0000;
      step();
    end
  endtask

  initial begin
    t_reset();
    t_warmup();
    t_order();
    t_clamp_isolation();
    t_endcodes();
    t_reset();
    t_warmup();
    t_clamp_isolation();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule